// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Controller

This block decides, for the instruction now in the execute stage of a five-stage load/store pipeline, where each of its two ALU source operands should come from. It takes the two source register numbers of that instruction and compares them with the destination numbers of the two instructions ahead of it: the one in the memory stage and the one in write-back. A producer counts only if it will write the register file and its destination is not register 0. When both producers write the needed register, the memory-stage result is chosen because it is the newer value. Each operand is decided separately, so one, both or neither can be bypassed in the same cycle. With this in place, dependent ALU instructions run back to back with no stall.

A second path serves a load followed at once by a store of the loaded register. When that pattern is present, the value being written back by the load replaces the store's write data in the memory stage, so the copy needs no stall.

The select lines leave the block combinationally. A thin registered stage also holds the two operand multiplexers and the store-data multiplexer, so that the chosen data values can be seen one clock later. The register file, ALU, memories and stall logic sit outside the block.

Top module: `bypass_unit`

## Requirements
- R1: While `rst_n` is low, `opnd_a_q`, `opnd_b_q` and `store_data_q` are all zero.
- R2: An operand select is 2'b10 (memory-stage result) when that operand's source index equals `mem_dst_idx`, `mem_wr_en` is 1 and `mem_dst_idx` is nonzero.
- R3: An operand select is 2'b01 (write-back value) when the memory-stage condition of R2 fails and the source index equals `wb_dst_idx`, with `wb_wr_en` at 1 and `wb_dst_idx` nonzero.
- R4: When both the memory-stage and the write-back producers qualify for the same operand, the select is 2'b10.
- R5: A source index of 0 always gives select 2'b00 (execute-stage value), whatever the producers hold.
- R6: A producer whose write enable is 0 is never forwarded. If neither producer qualifies, the select is 2'b00.
- R7: `sel_a` depends only on `ex_src_a_idx` and `sel_b` only on `ex_src_b_idx`, so the two selects can differ in the same cycle.
- R8: `store_sel` is 1 exactly when `mem_is_store`, `wb_is_load` and `wb_wr_en` are 1, `wb_dst_idx` is nonzero and `wb_dst_idx` equals `mem_store_src_idx`.
- R9: After a rising clock edge, each `opnd_*_q` holds the execute-stage value, `mem_result` or `wb_value` seen before the edge, as picked by the select code (00, 10 or 01).
- R10: After a rising clock edge, `store_data_q` holds `wb_value` if `store_sel` was 1 before the edge, and `mem_store_val` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_src_a_idx | input | 5 | First source register number in execute |
| ex_src_b_idx | input | 5 | Second source register number in execute |
| ex_src_a_val | input | 32 | First operand as read in decode |
| ex_src_b_val | input | 32 | Second operand as read in decode |
| mem_dst_idx | input | 5 | Destination of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_result | input | 32 | ALU result held in the memory stage |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_store_src_idx | input | 5 | Register whose value the store writes |
| mem_store_val | input | 32 | Store data carried down the pipeline |
| wb_dst_idx | input | 5 | Destination of the write-back instruction |
| wb_wr_en | input | 1 | Write-back instruction writes a register |
| wb_is_load | input | 1 | Write-back instruction is a load |
| wb_value | input | 32 | Value being written back |
| sel_a | output | 2 | First operand select: 00 none, 10 memory stage, 01 write-back |
| sel_b | output | 2 | Second operand select, same encoding |
| store_sel | output | 1 | Store data taken from write-back value |
| opnd_a_q | output | 32 | Registered first operand |
| opnd_b_q | output | 32 | Registered second operand |
| store_data_q | output | 32 | Registered store write data |

## Verification
The bench uses the default parameters: 32-bit data and a 32-entry register file, so indices are 5 bits wide. This covers both ends of the index range: register 0, which must never be forwarded, and register 31, the highest index, where a comparison that is too narrow would show. The data values on the four operand sources are distinct, so each registered operand shows which path was taken.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_ID     = 2'b00,
        SEL_WBRES  = 2'b01,
        SEL_MEMRES = 2'b10
    } opsel_e;

endpackage

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src_idx,
    input  logic [AW-1:0] mem_dst_idx,
    input  logic          mem_wr_en,
    input  logic [AW-1:0] wb_dst_idx,
    input  logic          wb_wr_en,
    output opsel_e        sel
);

    logic mem_hit;
    logic wb_hit;

    // A producer qualifies only when it really writes a nonzero register
    always_comb begin
        mem_hit = mem_wr_en && (mem_dst_idx != '0) && (mem_dst_idx == src_idx);
        wb_hit  = wb_wr_en  && (wb_dst_idx  != '0) && (wb_dst_idx  == src_idx);
    end

    // Newer result (memory stage) takes priority over write-back
    always_comb begin
        if (mem_hit)
            sel = SEL_MEMRES;
        else if (wb_hit)
            sel = SEL_WBRES;
        else
            sel = SEL_ID;
    end

endmodule

// File: rtl/operand_stage.sv
module operand_stage
    import fwd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  opsel_e        sel,
    input  logic [DW-1:0] id_val,
    input  logic [DW-1:0] mem_val,
    input  logic [DW-1:0] wb_val,
    output logic [DW-1:0] q
);

    logic [DW-1:0] picked;

    always_comb begin
        unique case (sel)
            SEL_MEMRES: picked = mem_val;
            SEL_WBRES:  picked = wb_val;
            default:    picked = id_val;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= picked;
    end

endmodule

// File: rtl/store_bypass_ctl.sv
module store_bypass_ctl #(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_is_store,
    input  logic [AW-1:0] mem_store_src_idx,
    input  logic [DW-1:0] mem_store_val,
    input  logic          wb_is_load,
    input  logic          wb_wr_en,
    input  logic [AW-1:0] wb_dst_idx,
    input  logic [DW-1:0] wb_value,
    output logic          use_wb,
    output logic [DW-1:0] data_q
);

    always_comb begin
        use_wb = mem_is_store && wb_is_load && wb_wr_en
              && (wb_dst_idx != '0) && (wb_dst_idx == mem_store_src_idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else
            data_q <= use_wb ? wb_value : mem_store_val;
    end

endmodule

// File: rtl/bypass_unit.sv
module bypass_unit
    import fwd_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_COUNT = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(REG_COUNT)-1:0] ex_src_a_idx,
    input  logic [$clog2(REG_COUNT)-1:0] ex_src_b_idx,
    input  logic [DATA_W-1:0]            ex_src_a_val,
    input  logic [DATA_W-1:0]            ex_src_b_val,
    input  logic [$clog2(REG_COUNT)-1:0] mem_dst_idx,
    input  logic                         mem_wr_en,
    input  logic [DATA_W-1:0]            mem_result,
    input  logic                         mem_is_store,
    input  logic [$clog2(REG_COUNT)-1:0] mem_store_src_idx,
    input  logic [DATA_W-1:0]            mem_store_val,
    input  logic [$clog2(REG_COUNT)-1:0] wb_dst_idx,
    input  logic                         wb_wr_en,
    input  logic                         wb_is_load,
    input  logic [DATA_W-1:0]            wb_value,
    output logic [1:0]                   sel_a,
    output logic [1:0]                   sel_b,
    output logic                         store_sel,
    output logic [DATA_W-1:0]            opnd_a_q,
    output logic [DATA_W-1:0]            opnd_b_q,
    output logic [DATA_W-1:0]            store_data_q
);

    localparam int AW      = $clog2(REG_COUNT);
    localparam int NUM_OPS = 2;

    logic [AW-1:0]     src_idx [NUM_OPS];
    logic [DATA_W-1:0] id_val  [NUM_OPS];
    opsel_e            lane_sel[NUM_OPS];
    logic [DATA_W-1:0] lane_q  [NUM_OPS];

    always_comb begin
        src_idx[0] = ex_src_a_idx;
        src_idx[1] = ex_src_b_idx;
        id_val[0]  = ex_src_a_val;
        id_val[1]  = ex_src_b_val;
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_lane
        fwd_select #(.AW(AW)) u_sel (
            .src_idx     (src_idx[g]),
            .mem_dst_idx (mem_dst_idx),
            .mem_wr_en   (mem_wr_en),
            .wb_dst_idx  (wb_dst_idx),
            .wb_wr_en    (wb_wr_en),
            .sel         (lane_sel[g])
        );

        operand_stage #(.DW(DATA_W)) u_opnd (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (lane_sel[g]),
            .id_val  (id_val[g]),
            .mem_val (mem_result),
            .wb_val  (wb_value),
            .q       (lane_q[g])
        );
    end

    store_bypass_ctl #(.AW(AW), .DW(DATA_W)) u_store (
        .clk               (clk),
        .rst_n             (rst_n),
        .mem_is_store      (mem_is_store),
        .mem_store_src_idx (mem_store_src_idx),
        .mem_store_val     (mem_store_val),
        .wb_is_load        (wb_is_load),
        .wb_wr_en          (wb_wr_en),
        .wb_dst_idx        (wb_dst_idx),
        .wb_value          (wb_value),
        .use_wb            (store_sel),
        .data_q            (store_data_q)
    );

    assign sel_a    = lane_sel[0];
    assign sel_b    = lane_sel[1];
    assign opnd_a_q = lane_q[0];
    assign opnd_b_q = lane_q[1];

    // R2
    sel_a_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_a != 2'b11);

    // R4
    both_hit_newer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && mem_dst_idx != '0 && mem_dst_idx == ex_src_a_idx)
        |-> sel_a == 2'b10);

    // R5
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_src_a_idx == '0 || ex_src_b_idx == '0)
        |-> ((ex_src_a_idx != '0 || sel_a == 2'b00) &&
             (ex_src_b_idx != '0 || sel_b == 2'b00)));

    // R6
    no_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_en && !wb_wr_en) |-> (sel_a == 2'b00 && sel_b == 2'b00));

    // R9
    opa_mem_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && sel_a == 2'b10) |=> opnd_a_q == $past(mem_result));

    // R9
    opb_wb_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && sel_b == 2'b01) |=> opnd_b_q == $past(wb_value));

    // R8
    store_needs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_sel |-> (mem_is_store && wb_is_load && wb_wr_en));

    // R10
    store_data_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && store_sel) |=> store_data_q == $past(wb_value));

endmodule

// File: tb/bypass_unit_test.sv
`timescale 1ns/1ps
module bypass_unit_test;

    localparam int AW = 5;
    localparam int DW = 32;
    localparam logic [DW-1:0] VAL_A  = 32'h1111_0001;
    localparam logic [DW-1:0] VAL_B  = 32'h2222_0002;
    localparam logic [DW-1:0] VAL_M  = 32'hAAAA_000A;
    localparam logic [DW-1:0] VAL_W  = 32'h5555_0005;
    localparam logic [DW-1:0] VAL_ST = 32'h7777_0007;

    typedef struct packed {
        logic [AW-1:0] sa;
        logic [AW-1:0] sb;
        logic [AW-1:0] md;
        logic          mw;
        logic [AW-1:0] wd;
        logic          ww;
        logic [1:0]    ea;
        logic [1:0]    eb;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'd1,  5'd2,  5'd1,  1'b1, 5'd9,  1'b1, 2'b10, 2'b00, 4'd2}, // R2
        '{5'd3,  5'd4,  5'd4,  1'b1, 5'd3,  1'b1, 2'b01, 2'b10, 4'd7}, // R7
        '{5'd5,  5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 2'b10, 2'b10, 4'd4}, // R4
        '{5'd6,  5'd7,  5'd8,  1'b1, 5'd7,  1'b1, 2'b00, 2'b01, 4'd3}, // R3
        '{5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00, 4'd5}, // R5
        '{5'd9,  5'd9,  5'd9,  1'b0, 5'd9,  1'b0, 2'b00, 2'b00, 4'd6}, // R6
        '{5'd9,  5'd9,  5'd9,  1'b0, 5'd9,  1'b1, 2'b01, 2'b01, 4'd6}, // R6
        '{5'd31, 5'd30, 5'd31, 1'b1, 5'd30, 1'b1, 2'b10, 2'b01, 4'd7}, // R7
        '{5'd12, 5'd0,  5'd0,  1'b1, 5'd12, 1'b1, 2'b01, 2'b00, 4'd5}, // R5
        '{5'd14, 5'd15, 5'd14, 1'b1, 5'd14, 1'b0, 2'b10, 2'b00, 4'd2}  // R2
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic [AW-1:0]   ex_src_a_idx, ex_src_b_idx, mem_dst_idx, mem_store_src_idx, wb_dst_idx;
    logic [DW-1:0]   ex_src_a_val, ex_src_b_val, mem_result, mem_store_val, wb_value;
    logic            mem_wr_en, mem_is_store, wb_wr_en, wb_is_load;
    logic [1:0]      sel_a, sel_b;
    logic            store_sel;
    logic [DW-1:0]   opnd_a_q, opnd_b_q, store_data_q;

    int total  = 0;
    int failed = 0;

    always #10 clk = ~clk;

    bypass_unit uut (
        .clk(clk), .rst_n(rst_n),
        .ex_src_a_idx(ex_src_a_idx), .ex_src_b_idx(ex_src_b_idx),
        .ex_src_a_val(ex_src_a_val), .ex_src_b_val(ex_src_b_val),
        .mem_dst_idx(mem_dst_idx), .mem_wr_en(mem_wr_en), .mem_result(mem_result),
        .mem_is_store(mem_is_store), .mem_store_src_idx(mem_store_src_idx),
        .mem_store_val(mem_store_val),
        .wb_dst_idx(wb_dst_idx), .wb_wr_en(wb_wr_en), .wb_is_load(wb_is_load),
        .wb_value(wb_value),
        .sel_a(sel_a), .sel_b(sel_b), .store_sel(store_sel),
        .opnd_a_q(opnd_a_q), .opnd_b_q(opnd_b_q), .store_data_q(store_data_q)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Value chosen by a select code: 00 execute, 10 memory stage, 01 write-back
    function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] idv);
        case (s)
            2'b10:   return VAL_M;
            2'b01:   return VAL_W;
            default: return idv;
        endcase
    endfunction

    task automatic store_case(input logic st, input logic ld, input logic ww,
                              input logic [AW-1:0] wd, input logic [AW-1:0] rt,
                              input logic exp_sel, input string req);
        @(negedge clk);
        mem_wr_en = 1'b0;
        mem_is_store = st; wb_is_load = ld; wb_wr_en = ww;
        wb_dst_idx = wd; mem_store_src_idx = rt;
        #2;
        chk({req, " store_sel"}, {31'd0, store_sel}, {31'd0, exp_sel});
        @(posedge clk);
        @(negedge clk);
        chk({"R10 ", req, " store_data_q"}, store_data_q, exp_sel ? VAL_W : VAL_ST);
    endtask

    initial begin
        rst_n = 1'b0;
        ex_src_a_val = VAL_A; ex_src_b_val = VAL_B;
        mem_result = VAL_M; wb_value = VAL_W; mem_store_val = VAL_ST;
        ex_src_a_idx = 5'd1; ex_src_b_idx = 5'd1;
        mem_dst_idx = 5'd1; mem_wr_en = 1'b1;
        wb_dst_idx = 5'd1; wb_wr_en = 1'b1; wb_is_load = 1'b1;
        mem_is_store = 1'b1; mem_store_src_idx = 5'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: registered outputs held at zero in reset
        chk("R1 opnd_a_q", opnd_a_q, '0);
        chk("R1 opnd_b_q", opnd_b_q, '0);
        chk("R1 store_data_q", store_data_q, '0);
        rst_n = 1'b1;
        mem_is_store = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ex_src_a_idx = VECS[i].sa; ex_src_b_idx = VECS[i].sb;
            mem_dst_idx = VECS[i].md;  mem_wr_en = VECS[i].mw;
            wb_dst_idx = VECS[i].wd;   wb_wr_en = VECS[i].ww;
            #2;
            chk($sformatf("R%0d vec%0d sel_a", VECS[i].req, i), {30'd0, sel_a}, {30'd0, VECS[i].ea});
            chk($sformatf("R%0d vec%0d sel_b", VECS[i].req, i), {30'd0, sel_b}, {30'd0, VECS[i].eb});
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R9 vec%0d opnd_a_q", i), opnd_a_q, pick(VECS[i].ea, VAL_A));
            chk($sformatf("R9 vec%0d opnd_b_q", i), opnd_b_q, pick(VECS[i].eb, VAL_B));
        end

        // R8: load then store of the same register
        store_case(1'b1, 1'b1, 1'b1, 5'd8,  5'd8,  1'b1, "R8 match");
        store_case(1'b1, 1'b0, 1'b1, 5'd8,  5'd8,  1'b0, "R8 not_load");
        store_case(1'b0, 1'b1, 1'b1, 5'd8,  5'd8,  1'b0, "R8 not_store");
        store_case(1'b1, 1'b1, 1'b0, 5'd8,  5'd8,  1'b0, "R8 no_write");
        store_case(1'b1, 1'b1, 1'b1, 5'd0,  5'd0,  1'b0, "R8 reg_zero");
        store_case(1'b1, 1'b1, 1'b1, 5'd31, 5'd30, 1'b0, "R8 idx_diff");
        store_case(1'b1, 1'b1, 1'b1, 5'd31, 5'd31, 1'b1, "R8 top_reg");

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        #(200000 * 20);
        total++;
        failed++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule